// File: doc/BRIEF.md
# Reed-Solomon Syndrome Generator for Streamed Flash Pages

This block computes the syndromes of a Reed-Solomon codeword over GF(2^12) while a flash page passes by one byte at a time. A repacking stage turns the byte stream into 12-bit symbols. Every symbol is folded into a bank of Horner accumulators, one per syndrome, and each accumulator scales by its own fixed power of the field generator.

A frame opens with a start pulse, which may share a cycle with the first byte. It ends with the byte that carries the last marker. Once the final symbol has been absorbed, the block raises a done flag. It then holds the syndromes, two to a 32-bit word, and raises an error flag when any syndrome is nonzero. A downstream decoder uses these words to locate and correct errors. Bytes that arrive after the last one and before the next start are dropped.

Top module: `rs_syndrome_gen`

## Requirements
- R1: After reset, done_o and err_o are 0 and every syndrome word reads 0.
- R2: Arithmetic is in GF(2^12) built on x^12+x^6+x^4+x+1 (0x1053), with generator alpha = 0x002. For each absorbed symbol s, syndrome j becomes S_j·alpha^(FIRST_ROOT+j) XOR s. The defaults are FIRST_ROOT = 0 and NUM_SYN = 8.
- R3: The first symbol of a frame is {4'h0, byte0}.
- R4: The bytes after the first are taken in groups of three, a b c, and each group yields two symbols: {a, b[7:4]} and {b[3:0], c}.
- R5: A frame that ends part-way through a symbol is zero-padded in its low bits. If it ends on the first byte a of a group, the final symbol is {a, 4'h0}. If it ends on b, the leftover symbol {b[3:0], 8'h00} is absorbed on the next clock, and in_valid_i is ignored during that clock.
- R6: done_o is visible in the cycle after the clock edge that absorbs the final symbol. It stays high until a start pulse.
- R7: Word k carries S_2k in bits 11:0 and S_2k+1 in bits 27:16. All other bits are 0.
- R8: err_o equals done_o AND (at least one syndrome is nonzero). An all-zero page gives err_o = 0.
- R9: A start pulse clears every syndrome and done_o. A byte valid in the same cycle as start becomes byte0 of the new frame.
- R10: Bytes presented after the last byte and before the next start change neither the syndromes nor done_o.
- R11: Cycles with in_valid_i low do not advance the stream. A frame sent with idle gaps yields the same syndromes as the same frame sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a frame; clears syndromes and done |
| in_valid_i | input | 1 | in_byte_i carries a page byte |
| in_byte_i | input | 8 | Page byte |
| in_last_i | input | 1 | Marks the final byte of the frame |
| syn_words_o | output | NUM_SYN/2 x 32 | Packed syndromes, two per word |
| done_o | output | 1 | Syndromes are final |
| err_o | output | 1 | Final syndromes are not all zero |

## Verification
On every cycle, the embedded assertions check the following: the flush symbol follows a last byte that ends mid-symbol, the packer stays silent after the frame ends, done follows the final symbol and falls on start, the first-root syndrome behaves as a running XOR, a clear zeroes each accumulator, and the result words stay frozen while done is high. The field arithmetic itself, the exact symbol packing, zero padding, word layout and error flag can only be shown by the bench's scenarios. For those, an independent bit-stream model of the page computes the expected syndromes.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
   localparam int SYM_W = 12;
   typedef logic [SYM_W-1:0] gf_t;

   typedef enum logic [2:0] {
      PK_FIRST, PK_HI, PK_MID, PK_LO, PK_FLUSH, PK_IDLE
   } pk_state_e;

   // multiply by alpha (x) modulo the field polynomial
   function automatic gf_t gf_xtime(gf_t a, logic [SYM_W:0] poly);
      gf_t sh;
      sh = gf_t'(a << 1);
      return a[SYM_W-1] ? (sh ^ poly[SYM_W-1:0]) : sh;
   endfunction

   // general product, MSB-first shift and add
   function automatic gf_t gf_mul(gf_t a, gf_t b, logic [SYM_W:0] poly);
      gf_t r;
      r = '0;
      for (int i = SYM_W - 1; i >= 0; i--) begin
         r = gf_xtime(r, poly);
         if (b[i]) r = r ^ a;
      end
      return r;
   endfunction

   // alpha^e, evaluated at elaboration for the fixed roots
   function automatic gf_t gf_alpha_pow(int unsigned e, logic [SYM_W:0] poly);
      gf_t r;
      r = gf_t'(1);
      for (int unsigned i = 0; i < e; i++) r = gf_xtime(r, poly);
      return r;
   endfunction
endpackage

// File: rtl/rs_sym_packer.sv
module rs_sym_packer
   import rs_syn_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       valid_i,
   input  logic [7:0] byte_i,
   input  logic       last_i,
   output logic       sym_valid_o,
   output gf_t        sym_o,
   output logic       sym_last_o
);
   pk_state_e  state, eff, nxt;
   logic [7:0] hold, hold_nxt;

   always_comb begin
      eff         = start_i ? PK_FIRST : state;
      nxt         = eff;
      hold_nxt    = hold;
      sym_valid_o = 1'b0;
      sym_o       = '0;
      sym_last_o  = 1'b0;
      case (eff)
         PK_FIRST: if (valid_i) begin
            sym_valid_o = 1'b1;
            sym_o       = {4'h0, byte_i};
            if (last_i) begin sym_last_o = 1'b1; nxt = PK_IDLE; end
            else nxt = PK_HI;
         end
         PK_HI: if (valid_i) begin
            hold_nxt = byte_i;
            if (last_i) begin
               sym_valid_o = 1'b1;
               sym_o       = {byte_i, 4'h0};
               sym_last_o  = 1'b1;
               nxt         = PK_IDLE;
            end else nxt = PK_MID;
         end
         PK_MID: if (valid_i) begin
            sym_valid_o = 1'b1;
            sym_o       = {hold, byte_i[7:4]};
            hold_nxt    = {4'h0, byte_i[3:0]};
            nxt         = last_i ? PK_FLUSH : PK_LO;
         end
         PK_LO: if (valid_i) begin
            sym_valid_o = 1'b1;
            sym_o       = {hold[3:0], byte_i};
            if (last_i) begin sym_last_o = 1'b1; nxt = PK_IDLE; end
            else nxt = PK_HI;
         end
         PK_FLUSH: begin
            sym_valid_o = 1'b1;
            sym_o       = {hold[3:0], 8'h00};
            sym_last_o  = 1'b1;
            nxt         = PK_IDLE;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PK_FIRST;
         hold  <= '0;
      end else begin
         state <= nxt;
         hold  <= hold_nxt;
      end
   end

   AST_FLUSH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && last_i && !start_i && state == PK_MID)
      |=> (start_i || (sym_valid_o && sym_last_o)));  // R5

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PK_IDLE && !start_i) |-> !sym_valid_o);  // R10
endmodule

// File: rtl/rs_syn_lane.sv
module rs_syn_lane
   import rs_syn_pkg::*;
#(
   parameter int unsigned       ROOT_EXP = 0,
   parameter logic [SYM_W:0]    GF_POLY  = 13'h1053
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   input  gf_t  sym_i,
   output gf_t  syn_o
);
   localparam gf_t ROOT = gf_alpha_pow(ROOT_EXP, GF_POLY);

   gf_t acc, base, scaled;

   assign base  = clr_i ? '0 : acc;
   assign syn_o = acc;

   generate
      if (ROOT_EXP == 0) begin : g_unity
         assign scaled = base;
         AST_UNITY_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i && !clr_i) |=> (syn_o == ($past(syn_o) ^ $past(sym_i))));  // R2
      end else begin : g_scale
         assign scaled = gf_mul(base, ROOT, GF_POLY);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (en_i)   acc <= scaled ^ sym_i;
      else if (clr_i)  acc <= '0;
   end

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !en_i) |=> (syn_o == '0));  // R9
endmodule

// File: rtl/rs_syndrome_gen.sv
module rs_syndrome_gen
   import rs_syn_pkg::*;
#(
   parameter int unsigned    NUM_SYN    = 8,
   parameter int unsigned    FIRST_ROOT = 0,
   parameter logic [12:0]    GF_POLY    = 13'h1053,
   localparam int unsigned   NUM_WORDS  = NUM_SYN / 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      in_valid_i,
   input  logic [7:0]                in_byte_i,
   input  logic                      in_last_i,
   output logic [NUM_WORDS-1:0][31:0] syn_words_o,
   output logic                      done_o,
   output logic                      err_o
);
   generate
      if (NUM_SYN < 2 || (NUM_SYN % 2) != 0) begin : g_bad_count
         $error("NUM_SYN must be even and at least 2");
      end
      if (FIRST_ROOT + NUM_SYN > 4095) begin : g_bad_root
         $error("root exponents exceed the field order");
      end
      if (GF_POLY[12] != 1'b1 || GF_POLY[0] != 1'b1) begin : g_bad_poly
         $error("field polynomial must have degree 12 and a constant term");
      end
   endgenerate

   logic sym_valid, sym_last;
   gf_t  sym;
   gf_t  syn [NUM_SYN];
   logic done_q;

   rs_sym_packer u_packer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .valid_i     (in_valid_i),
      .byte_i      (in_byte_i),
      .last_i      (in_last_i),
      .sym_valid_o (sym_valid),
      .sym_o       (sym),
      .sym_last_o  (sym_last)
   );

   generate
      for (genvar j = 0; j < NUM_SYN; j++) begin : g_lane
         rs_syn_lane #(
            .ROOT_EXP (FIRST_ROOT + j),
            .GF_POLY  (GF_POLY)
         ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (start_i),
            .en_i  (sym_valid),
            .sym_i (sym),
            .syn_o (syn[j])
         );
      end
      for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
         assign syn_words_o[k] = {4'h0, syn[2*k+1], 4'h0, syn[2*k]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    done_q <= 1'b0;
      else if (sym_valid && sym_last) done_q <= 1'b1;
      else if (start_i)              done_q <= 1'b0;
   end

   always_comb begin
      err_o = 1'b0;
      for (int j = 0; j < NUM_SYN; j++) err_o = err_o | (|syn[j]);
      err_o = err_o & done_q;
   end

   assign done_o = done_q;

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_last) |=> done_o);  // R6

   AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !(sym_valid && sym_last)) |=> !done_o);  // R9

   AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> $stable(syn_words_o));  // R10
endmodule

// File: tb/rs_syndrome_gen_bench.sv
`timescale 1ns/1ps
module rs_syndrome_gen_bench;
   localparam int NS = 8;
   localparam int NW = NS / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, in_valid_i = 1'b0, in_last_i = 1'b0;
   logic [7:0] in_byte_i = 8'h00;
   logic [NW-1:0][31:0] syn_words_o;
   logic done_o, err_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0]  frame [0:63];
   logic [11:0] exp_syn [NS];

   always #4 clk = ~clk;  // 125 MHz

   rs_syndrome_gen u_rs_syndrome_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
      .in_byte_i(in_byte_i), .in_last_i(in_last_i),
      .syn_words_o(syn_words_o), .done_o(done_o), .err_o(err_o)
   );

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [11:0] mx(logic [11:0] a);
      return a[11] ? ({a[10:0], 1'b0} ^ 12'h053) : {a[10:0], 1'b0};
   endfunction

   function automatic logic [11:0] mul(logic [11:0] a, logic [11:0] b);
      logic [11:0] r = '0;
      logic [11:0] t = a;
      for (int i = 0; i < 12; i++) begin
         if (b[i]) r = r ^ t;
         t = mx(t);
      end
      return r;
   endfunction

   // page as a bit string: four zero bits, then bytes MSB first, chopped into 12-bit symbols
   function automatic bit stream_bit(int p, int n);
      if (p < 4) return 1'b0;
      if (p - 4 >= 8 * n) return 1'b0;
      return frame[(p - 4) / 8][7 - ((p - 4) % 8)];
   endfunction

   task automatic compute_expected(int n);
      int total = 4 + 8 * n;
      int nsym  = (total + 11) / 12;
      logic [11:0] root [NS];
      root[0] = 12'h001;
      for (int j = 1; j < NS; j++) root[j] = mx(root[j-1]);
      for (int j = 0; j < NS; j++) exp_syn[j] = '0;
      for (int k = 0; k < nsym; k++) begin
         logic [11:0] s = '0;
         for (int b = 0; b < 12; b++) s[11-b] = stream_bit(12 * k + b, n);
         for (int j = 0; j < NS; j++) exp_syn[j] = mul(exp_syn[j], root[j]) ^ s;
      end
   endtask

   task automatic check_result(string req);
      bit any = 1'b0;
      for (int j = 0; j < NS; j++) any |= (exp_syn[j] != 0);
      for (int k = 0; k < NW; k++)
         check({req, " R7 word"}, syn_words_o[k], {4'h0, exp_syn[2*k+1], 4'h0, exp_syn[2*k]});
      check({req, " R6 done"}, done_o, 1);
      check({req, " R8 err"}, err_o, any);
   endtask

   // present frame[0:n-1]; returns at the negedge where done should be visible
   task automatic drive_frame(int n, bit gaps, bit start_same);
      if (!start_same) begin
         start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      end
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 2 == 1)) begin
            in_valid_i = 1'b0; @(negedge clk);
         end
         in_valid_i = 1'b1; in_byte_i = frame[i]; in_last_i = (i == n - 1);
         start_i = (start_same && i == 0);
         @(negedge clk);
      end
      in_valid_i = 1'b0; in_last_i = 1'b0; start_i = 1'b0;
      if (n >= 3 && ((n - 1) % 3) == 2) begin
         check("R5 flush cycle done low", done_o, 0);
         @(negedge clk);
      end
   endtask

   task automatic fill(int n, int seed);
      for (int i = 0; i < n; i++) frame[i] = 8'(i * 37 + seed * 11 + 5);
   endtask

   task automatic t_reset;
      for (int k = 0; k < NW; k++) check("R1 reset word", syn_words_o[k], 0);
      check("R1 reset done", done_o, 0);
      check("R1 reset err", err_o, 0);
   endtask

   task automatic t_single_byte;
      frame[0] = 8'h5A;
      compute_expected(1);
      drive_frame(1, 0, 0);
      check("R3 first symbol S0", {20'h0, exp_syn[0]}, 32'h05A);
      check_result("R3 single byte");
   endtask

   task automatic t_zero_page;
      for (int i = 0; i < 10; i++) frame[i] = 8'h00;
      compute_expected(10);
      drive_frame(10, 0, 0);
      check_result("R8 zero page");
   endtask

   task automatic t_lengths;
      int lens [5] = '{2, 3, 4, 20, 50};
      foreach (lens[i]) begin
         fill(lens[i], i + 1);
         compute_expected(lens[i]);
         drive_frame(lens[i], 0, 0);
         check_result(lens[i] < 4 ? "R5 padded tail" : "R2 R4 packed page");
      end
   endtask

   task automatic t_gaps;
      fill(23, 9);
      compute_expected(23);
      drive_frame(23, 1, 0);
      check_result("R11 gapped stream");
   endtask

   task automatic t_stray;
      fill(7, 4);
      compute_expected(7);
      drive_frame(7, 0, 0);
      for (int i = 0; i < 3; i++) begin
         in_valid_i = 1'b1; in_byte_i = 8'hC3 + 8'(i); in_last_i = (i == 2);
         @(negedge clk);
      end
      in_valid_i = 1'b0; in_last_i = 1'b0;
      @(negedge clk);
      check_result("R10 stray bytes");
   endtask

   task automatic t_start_clear;
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      for (int k = 0; k < NW; k++) check("R9 start clears word", syn_words_o[k], 0);
      check("R9 start clears done", done_o, 0);
      check("R9 start clears err", err_o, 0);
   endtask

   task automatic t_start_with_byte;
      fill(11, 13);
      compute_expected(11);
      drive_frame(11, 0, 1);
      check_result("R9 start with byte");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_byte();
      t_zero_page();
      t_lengths();
      t_gaps();
      t_stray();
      t_start_with_byte();
      t_start_clear();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule